// File: doc/BRIEF.md
# NAND Flash Command Front-End

This block connects a register-mapped host port to an 8-bit asynchronous NAND device. Host writes to four push registers place command, address, data or read-request entries into a small ordered queue. A pin sequencer takes entries from the queue one at a time. For each entry it drives one device cycle on the NAND pins: command cycles raise CLE, address cycles raise ALE, and data cycles raise neither. Every cycle uses a programmable strobe low time.

Reading from the device takes two phases. A write of any value to the read-request register queues one RE# cycle. At the end of that cycle the device byte is captured into the read-data register, and a sticky read-ready flag is set. Software collects the byte and then clears the flag by writing one to it.

A status register mirrors the synchronised ready/busy pin and reports the queue fill state. An interrupt-status register holds sticky events, and a mask gates those events onto one interrupt line. A self-clearing clear bit zeroes the transfer counter.

Top module: `nand_cmd_frontend`

## Requirements
- R1: The status register (offset 1) has these fields. Bit 0 is not-busy: the ready/busy pin after a two-flop synchroniser. Bit 1 is queue-full and bit 4 is queue-empty. Bits 2 and 3 are page-write and page-read pending, and they read 0 because this block makes no page transfers.
- R2: A write to offset 4 queues a command entry, offset 5 an address entry and offset 6 a data entry. Each entry produces one WE# cycle. CLE is high for a command cycle, ALE is high for an address cycle, and both are low for a data cycle. The data byte is driven on the output pins with the output-enable high for the whole cycle.
- R3: A push while the queue is full (depth 4) drops the entry and sets interrupt-status bit 1 (overflow).
- R4: A strobe stays low for the programmed delay plus one clock. The write-strobe delay is control bits [11:8] and the read-strobe delay is control bits [7:4]. After the strobe rises, the pins stay high for exactly one clock; the next queued entry then starts at once. Control (offset 0) keeps only bits 0, 1 and 4 to 11.
- R5: A write of any value to offset 7 queues one RE# cycle. The device byte present in the last low clock is captured into read-data (offset 8), and interrupt-status bit 3 (read-ready) is set.
- R6: Interrupt status (offset 2) is sticky. Writing 1 to a bit clears it. An event arriving in the same clock as the clear keeps the bit set.
- R7: Interrupt-status bit 0 sets on a rising edge of the synchronised not-busy signal. Bit 2 sets when the queue goes from non-empty to empty.
- R8: The interrupt output is high exactly when a bit is set in both interrupt status and the mask (offset 3, five bits).
- R9: Writing 1 to bit 0 of offset 9 makes that bit read 1 for three clocks. During those clocks the transfer counter (offset 10) is held at zero. Otherwise the counter counts completed device cycles.
- R10: After reset the control, mask, interrupt-status, read-data and counter registers are zero. The queue is empty and all strobes are high.
- R11: Queued entries reach the pins in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hwr | input | 1 | Host register write strobe |
| hwaddr | input | 4 | Host write register offset |
| hwdata | input | 16 | Host write data |
| hraddr | input | 4 | Host read register offset |
| hrdata | output | 16 | Host read data (combinational) |
| irq | output | 1 | Masked interrupt |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Byte driven to device |
| nand_doe | output | 1 | Output enable for nand_dout |
| nand_din | input | 8 | Byte from device |
| nand_rb | input | 1 | Device ready/busy, high when ready |

## Verification
The assertions assume these things about the inputs:
- The host issues at most one register write per clock.
- The device byte is stable across the clock edge that ends a read strobe.
- The ready/busy pin changes only between clock edges.

The stimulus drives every input shortly after the falling clock edge and releases write strobes just after the rising edge. It changes the device byte and the ready/busy level only while the sequencer is idle or between those edges. Overflow is provoked only by stretching the write strobe to its longest delay and pushing back to back, so the sequencer stays busy while the queue fills.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_ADDR = 2'd1,
        K_DATA = 2'd2,
        K_READ = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] data;
    } entry_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2
    } seq_e;

    localparam int          IRQ_W     = 5;
    localparam int          DLY_W     = 4;
    localparam logic [11:0] CTRL_KEEP = 12'hFF3;

    localparam logic [3:0] RA_CTRL  = 4'd0;
    localparam logic [3:0] RA_STAT  = 4'd1;
    localparam logic [3:0] RA_ISTAT = 4'd2;
    localparam logic [3:0] RA_IMASK = 4'd3;
    localparam logic [3:0] RA_RDATA = 4'd8;
    localparam logic [3:0] RA_CLR   = 4'd9;
    localparam logic [3:0] RA_XCNT  = 4'd10;

    localparam int IB_RDY   = 0;
    localparam int IB_OVF   = 1;
    localparam int IB_DRAIN = 2;
    localparam int IB_RD    = 3;

    function automatic logic is_push(input logic [3:0] a);
        return a[3:2] == 2'b01;
    endfunction

    function automatic kind_e kind_of(input logic [3:0] a);
        return kind_e'(a[1:0]);
    endfunction

endpackage

// File: rtl/nfe_queue.sv
module nfe_queue
    import nfe_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  logic   pop,
    input  entry_t din,
    output entry_t dout,
    output logic   full,
    output logic   empty,
    output logic   drained
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    entry_t        mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drained = do_pop && !do_push && (cnt == CW'(1));
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/nfe_sync.sv
module nfe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/nfe_seq.sv
module nfe_seq
    import nfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             avail,
    input  entry_t           head,
    input  logic [DLY_W-1:0] wr_dly,
    input  logic [DLY_W-1:0] rd_dly,
    input  logic [7:0]       din,
    output logic             pop,
    output logic             cyc_done,
    output logic             cap_valid,
    output logic [7:0]       cap_data,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       dout,
    output logic             doe
);
    seq_e             st;
    entry_t           cur;
    logic [DLY_W-1:0] cnt;
    logic             active, is_rd;

    assign pop = (st != S_LOW) && avail;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            cur <= '0;
            cnt <= '0;
        end else if (st == S_LOW) begin
            if (cnt == '0) st  <= S_HIGH;
            else           cnt <= cnt - DLY_W'(1);
        end else if (avail) begin
            cur <= head;
            st  <= S_LOW;
            cnt <= (head.kind == K_READ) ? rd_dly : wr_dly;
        end else begin
            st <= S_IDLE;
        end
    end

    assign active    = (st != S_IDLE);
    assign is_rd     = (cur.kind == K_READ);
    assign cyc_done  = (st == S_LOW) && (cnt == '0);
    assign cap_valid = cyc_done && is_rd;
    assign cap_data  = din;
    assign we_n      = !((st == S_LOW) && !is_rd);
    assign re_n      = !((st == S_LOW) && is_rd);
    assign cle       = active && (cur.kind == K_CMD);
    assign ale       = active && (cur.kind == K_ADDR);
    assign doe       = active && !is_rd;
    assign dout      = doe ? cur.data : 8'h00;
endmodule

// File: rtl/nand_cmd_frontend.sv
module nand_cmd_frontend
    import nfe_pkg::*;
#(
    parameter int QDEPTH      = 4,
    parameter int CLR_CYCLES  = 3,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hwr,
    input  logic [3:0]  hwaddr,
    input  logic [15:0] hwdata,
    input  logic [3:0]  hraddr,
    output logic [15:0] hrdata,
    output logic        irq,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dout,
    output logic        nand_doe,
    input  logic [7:0]  nand_din,
    input  logic        nand_rb
);
    localparam int CLW = $clog2(CLR_CYCLES + 1);

    logic [11:0]      ctrl_q;
    logic [IRQ_W-1:0] istat, imask, iset, iclr;
    logic [7:0]       rdata;
    logic [CLW-1:0]   clr_left;
    logic [CNT_W-1:0] xcnt;
    logic             clr_busy;

    logic   push, push_full, full, empty, drained, pop;
    entry_t q_in, q_head;
    logic   rb_s, rb_prev;
    logic   cyc_done, cap_valid;
    logic [7:0] cap_data;

    assign push      = hwr && is_push(hwaddr);
    assign push_full = push && full;
    assign q_in      = '{kind: kind_of(hwaddr), data: hwdata[7:0]};

    nfe_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .din(q_in),
        .dout(q_head), .full(full), .empty(empty), .drained(drained)
    );

    nfe_seq u_seq (
        .clk(clk), .rst(rst), .avail(!empty), .head(q_head),
        .wr_dly(ctrl_q[11:8]), .rd_dly(ctrl_q[7:4]), .din(nand_din),
        .pop(pop), .cyc_done(cyc_done), .cap_valid(cap_valid), .cap_data(cap_data),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .dout(nand_dout), .doe(nand_doe)
    );

    nfe_sync #(.STAGES(SYNC_STAGES)) u_rb (
        .clk(clk), .rst(rst), .d(nand_rb), .q(rb_s)
    );

    always_comb begin
        iset           = '0;
        iset[IB_RDY]   = rb_s && !rb_prev;
        iset[IB_OVF]   = push_full;
        iset[IB_DRAIN] = drained;
        iset[IB_RD]    = cap_valid;
        iclr = (hwr && hwaddr == RA_ISTAT) ? hwdata[IRQ_W-1:0] : '0;
    end

    assign clr_busy = (clr_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            imask    <= '0;
            istat    <= '0;
            rdata    <= '0;
            rb_prev  <= 1'b0;
            clr_left <= '0;
            xcnt     <= '0;
        end else begin
            rb_prev <= rb_s;
            istat   <= (istat & ~iclr) | iset;
            if (hwr && hwaddr == RA_CTRL)  ctrl_q <= hwdata[11:0] & CTRL_KEEP;
            if (hwr && hwaddr == RA_IMASK) imask  <= hwdata[IRQ_W-1:0];
            if (cap_valid) rdata <= cap_data;
            if (hwr && hwaddr == RA_CLR && hwdata[0]) clr_left <= CLW'(CLR_CYCLES);
            else if (clr_busy)                        clr_left <= clr_left - CLW'(1);
            if (clr_busy)      xcnt <= '0;
            else if (cyc_done) xcnt <= xcnt + CNT_W'(1);
        end
    end

    assign irq = |(istat & imask);

    always_comb begin
        case (hraddr)
            RA_CTRL:  hrdata = {4'b0, ctrl_q};
            RA_STAT:  hrdata = {11'b0, empty, 1'b0, 1'b0, full, rb_s};
            RA_ISTAT: hrdata = 16'(istat);
            RA_IMASK: hrdata = 16'(imask);
            RA_RDATA: hrdata = {8'b0, rdata};
            RA_CLR:   hrdata = {15'b0, clr_busy};
            RA_XCNT:  hrdata = 16'(xcnt);
            default:  hrdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/nfe_checker.sv
module nfe_checker
    import nfe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             we_n,
    input logic             re_n,
    input logic             cle,
    input logic             ale,
    input logic [7:0]       dout,
    input logic             full,
    input logic             empty,
    input logic             push_full,
    input logic [IRQ_W-1:0] istat,
    input logic [IRQ_W-1:0] imask,
    input logic             irq,
    input logic             clr_busy,
    input logic [CNT_W-1:0] xcnt
);
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    assert_latch_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    assert_strobe_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> ($stable(dout) && $stable(cle) && $stable(ale)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        push_full |=> istat[IB_OVF]);

    assert_rd_ready_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(re_n) |-> istat[IB_RD]);

    assert_full_empty_R1: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr_busy |=> (xcnt == '0));

    assert_irq_mask_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (imask != '0));
endmodule

bind nand_cmd_frontend nfe_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .we_n(nand_we_n), .re_n(nand_re_n),
    .cle(nand_cle), .ale(nand_ale), .dout(nand_dout),
    .full(full), .empty(empty), .push_full(push_full),
    .istat(istat), .imask(imask), .irq(irq),
    .clr_busy(clr_busy), .xcnt(xcnt)
);

// File: tb/sim_nand_cmd_frontend.sv
`timescale 1ns/100ps
module sim_nand_cmd_frontend;
    localparam int DEPTH = 4;
    localparam int CLRC  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hwr = 1'b0;
    logic [3:0]  hwaddr = '0;
    logic [15:0] hwdata = '0;
    logic [3:0]  hraddr = '0;
    logic [15:0] hrdata;
    logic        irq, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe;
    logic [7:0]  nand_dout;
    logic [7:0]  nand_din = 8'hA5;
    logic        nand_rb = 1'b1;

    always #5 clk = ~clk;

    nand_cmd_frontend u0 (
        .clk(clk), .rst(rst), .hwr(hwr), .hwaddr(hwaddr), .hwdata(hwdata),
        .hraddr(hraddr), .hrdata(hrdata), .irq(irq),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dout(nand_dout), .nand_doe(nand_doe),
        .nand_din(nand_din), .nand_rb(nand_rb)
    );

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    // behavioural reference model
    int mq[$];
    int mph, mleft, mcur, mctrl, mmask, mistat, mrdata, mclr, mxcnt;
    bit ms1, ms2, mprev;
    int sz, wd, rdd, setv, w1c;
    bit dopop, done, push, ovf;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            mph = 0; mleft = 0; mcur = 0; mctrl = 0; mmask = 0; mistat = 0;
            mrdata = 0; mclr = 0; mxcnt = 0; ms1 = 0; ms2 = 0; mprev = 0;
        end else begin
            sz    = mq.size();
            dopop = (mph != 1) && (sz > 0);
            done  = (mph == 1) && (mleft == 0);
            wd    = (mctrl >> 8) & 15;
            rdd   = (mctrl >> 4) & 15;
            push  = hwr && hwaddr >= 4 && hwaddr <= 7;
            ovf   = push && sz == DEPTH;
            setv  = 0;
            if (mph == 1) begin
                if (mleft == 0) begin
                    mph = 2;
                    if ((mcur >> 8) == 3) begin mrdata = nand_din; setv |= 8; end
                end else mleft--;
            end else if (dopop) begin
                mcur  = mq.pop_front();
                mph   = 1;
                mleft = ((mcur >> 8) == 3) ? rdd : wd;
            end else mph = 0;
            if (push && !ovf) mq.push_back(((int'(hwaddr) - 4) << 8) | int'(hwdata[7:0]));
            if (ovf) setv |= 2;
            if (sz > 0 && mq.size() == 0) setv |= 4;
            if (ms2 && !mprev) setv |= 1;
            mprev = ms2; ms2 = ms1; ms1 = nand_rb;
            w1c    = (hwr && hwaddr == 2) ? int'(hwdata[4:0]) : 0;
            mistat = ((mistat & ~w1c) | setv) & 31;
            if (hwr && hwaddr == 0) mctrl = int'(hwdata) & 'hFF3;
            if (hwr && hwaddr == 3) mmask = int'(hwdata) & 31;
            mxcnt = (mclr != 0) ? 0 : ((mxcnt + int'(done)) & 'hFFFF);
            if (hwr && hwaddr == 9 && hwdata[0]) mclr = CLRC;
            else if (mclr != 0) mclr--;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    int seen_stat, seen_istat, seen_rdata, seen_ctrl, seen_mask, seen_xcnt, seen_clr;

    // per-clock comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            automatic int k = mcur >> 8;
            automatic bit act = (mph != 0);
            chk("R2 cle",  int'(nand_cle),  int'(act && k == 0));
            chk("R2 ale",  int'(nand_ale),  int'(act && k == 1));
            chk("R2 doe",  int'(nand_doe),  int'(act && k != 3));
            chk("R2 dout", int'(nand_dout), (act && k != 3) ? (mcur & 255) : 0);
            chk("R4 we_n", int'(nand_we_n), int'(!(mph == 1 && k != 3)));
            chk("R4 re_n", int'(nand_re_n), int'(!(mph == 1 && k == 3)));
            chk("R8 irq",  int'(irq), int'((mistat & mmask) != 0));
            hraddr = 4'd1; #0.2 seen_stat = int'(hrdata);
            hraddr = 4'd2; #0.2 seen_istat = int'(hrdata);
            hraddr = 4'd8; #0.2 seen_rdata = int'(hrdata);
            hraddr = 4'd0; #0.2 seen_ctrl = int'(hrdata);
            hraddr = 4'd3; #0.2 seen_mask = int'(hrdata);
            hraddr = 4'd10; #0.2 seen_xcnt = int'(hrdata);
            hraddr = 4'd9; #0.2 seen_clr = int'(hrdata);
            chk("R1 status", seen_stat,
                (int'(mq.size() == 0) << 4) | (int'(mq.size() == DEPTH) << 1) | int'(ms2));
            chk("R6 istat", seen_istat, mistat);
            chk("R5 rdata", seen_rdata, mrdata);
            chk("R4 ctrl",  seen_ctrl, mctrl);
            chk("R8 mask",  seen_mask, mmask);
            chk("R9 xcnt",  seen_xcnt, mxcnt);
            chk("R9 clr",   seen_clr, int'(mclr != 0));
        end
    end

    // log of bytes presented on falling write strobes, for the ordering check
    int wlog[$];
    logic we_d = 1'b1;
    always @(posedge clk) begin
        if (we_d && !nand_we_n) wlog.push_back(int'(nand_dout));
        we_d <= nand_we_n;
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); #2;
        hwr = 1'b1; hwaddr = a; hwdata = d;
        @(posedge clk); #1;
        hwr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1.8;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle(1);
        // R10: reset state
        chk("R10 ctrl", seen_ctrl, 0);
        chk("R10 istat", seen_istat, 0);
        chk("R10 xcnt", seen_xcnt, 0);
        chk("R10 we_n", int'(nand_we_n), 1);
        idle(4);
        chk("R7 rdy edge", (seen_istat & 1), 1);

        // delays: write 2, read 1; mask everything
        wr(4'd0, 16'hF215);
        wr(4'd3, 16'h001F);
        wlog.delete();
        wr(4'd4, 16'h0080);
        wr(4'd5, 16'h0012);
        wr(4'd6, 16'h0034);
        wr(4'd6, 16'h0056);
        idle(30);
        chk("R11 count", wlog.size(), 4);
        if (wlog.size() == 4) begin
            chk("R11 order0", wlog[0], 'h80);
            chk("R11 order1", wlog[1], 'h12);
            chk("R11 order2", wlog[2], 'h34);
            chk("R11 order3", wlog[3], 'h56);
        end
        chk("R7 drain", (seen_istat >> 2) & 1, 1);

        // two-phase read
        nand_din = 8'h3C;
        wr(4'd7, 16'h0000);
        idle(10);
        chk("R5 rdata", seen_rdata, 'h3C);
        chk("R5 ready", (seen_istat >> 3) & 1, 1);
        wr(4'd2, 16'h0008);
        idle(1);
        chk("R6 w1c", (seen_istat >> 3) & 1, 0);

        // overflow with longest write strobe
        wr(4'd0, 16'h0F00);
        for (int i = 0; i < 6; i++) wr(4'd6, 16'(8'h40 + i));
        idle(1);
        chk("R3 ovf", (seen_istat >> 1) & 1, 1);
        chk("R1 full", (seen_stat >> 1) & 1, 1);
        idle(100);

        // ready/busy toggle
        wr(4'd2, 16'h001F);
        nand_rb = 1'b0;
        idle(5);
        chk("R1 busy", seen_stat & 1, 0);
        nand_rb = 1'b1;
        idle(5);
        chk("R7 rdy rise", seen_istat & 1, 1);

        // counter clear
        wr(4'd9, 16'h0001);
        idle(1);
        chk("R9 busy", seen_clr, 1);
        idle(4);
        chk("R9 done", seen_clr, 0);
        chk("R9 zero", seen_xcnt, 0);

        // mixed reads with zero delay, mask off
        wr(4'd0, 16'h0000);
        wr(4'd3, 16'h0000);
        nand_din = 8'hC3;
        wr(4'd7, 16'h0000);
        wr(4'd4, 16'h0070);
        wr(4'd7, 16'h0000);
        idle(12);
        chk("R8 masked", int'(irq), 0);
        idle(2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule